// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers single-cycle event pulses from a link layer into a sticky status register, one bit per source. Each bit stays set until software clears it. Clearing works by writing a word in which the bits to clear are 0 and the bits to keep are 1. A mask register filters the sources: a 1 in a mask bit hides that source from the interrupt line. A separate top-level enable bit then decides whether the combined request reaches the single interrupt output.

Software selects a register with a two-bit code and writes it in one cycle. The status, the mask and the enable bit are all visible on output ports. The interrupt output is registered, so it follows the internal state one clock later. After reset every source is masked and the enable is off, so nothing is signalled until software unmasks a source and sets the enable.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status reads 0, the mask reads 0x7FF (every source masked), the enable bit reads 0 and `irq_o` is 0.
- R2: An event pulse on `evt_i[i]` sets status bit i at the next clock edge. The bit stays set across later cycles until it is cleared.
- R3: A write with `wr_sel` = 0 (status) clears every status bit whose `wr_data` bit is 0 and leaves every bit whose `wr_data` bit is 1 unchanged. Writing 0 clears all bits.
- R4: If an event on bit i arrives in the same cycle as a write that clears bit i, the bit ends up set.
- R5: A write with `wr_sel` = 1 (mask) loads `wr_data[10:0]` into the mask. Events on masked sources are still recorded in the status.
- R6: `irq_o` equals, one clock after the state it is computed from, the OR over all bits of (status AND NOT mask), gated by the enable bit.
- R7: A write with `wr_sel` = 2 loads the enable from `wr_data[11]`. While the enable is 0, `irq_o` stays 0 whatever the status and mask hold. `wr_data[10:0]` has no effect on this write.
- R8: A write with `wr_sel` = 3 changes none of status, mask or enable.
- R9: The source bit positions are fixed: bit 0 is the device/command interrupt, bit 1 the critical error, bit 2 the error and bit 3 the link error. Status bit i and mask bit i refer to the same source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 11 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 none |
| wr_data | input | 12 | Write data; bit 11 is the enable bit |
| status_o | output | 11 | Sticky status register |
| mask_o | output | 11 | Mask register, 1 = source blocked |
| enable_o | output | 1 | Top-level interrupt enable |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `evt_i`, `wr_en`, `wr_sel` and `wr_data` settle between clock edges. They also assume `wr_sel` and `wr_data` matter only in cycles where `wr_en` is high. The clear and no-op properties are stated only for cycles with no event pulse, because an event may legally set a bit in the same cycle. The bench drives every input on the falling edge and keeps each event a single-cycle pulse. It combines events with clears only in the step that targets the set-over-clear priority.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int ISU_SRC_W  = 11;
    localparam int ISU_EN_BIT = 11;

    // source positions shared by status and mask
    localparam int SRC_DEVICE   = 0;
    localparam int SRC_CRITICAL = 1;
    localparam int SRC_ERROR    = 2;
    localparam int SRC_LINK     = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             clr_en,
    input  logic [SRC_W-1:0] keep_mask,
    output logic [SRC_W-1:0] status_o
);
    typedef struct packed {
        logic [SRC_W-1:0] bits;
    } bank_t;

    bank_t            bank_d, bank_q;
    logic [SRC_W-1:0] drop;

    // a bit is dropped only when the write holds 0 in its position
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        assign drop[i] = clr_en & ~keep_mask[i];
    end

    always_comb begin
        bank_d = bank_q;
        // event set has priority over a clear in the same cycle
        bank_d.bits = evt_i | (bank_q.bits & ~drop);
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign status_o = bank_q.bits;
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SRC_W-1:0] value,
    output logic [SRC_W-1:0] mask_o
);
    typedef struct packed {
        logic [SRC_W-1:0] bits;
    } mask_t;

    mask_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (load) mask_d.bits = value;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '{bits: '1};
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q.bits;
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate #(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_load,
    input  logic             en_value,
    input  logic [SRC_W-1:0] status_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic             enable_o,
    output logic             irq_o
);
    typedef struct packed {
        logic en;
        logic irq;
    } gate_t;

    gate_t            gate_d, gate_q;
    logic [SRC_W-1:0] live;

    assign live = status_i & ~mask_i;

    always_comb begin
        gate_d = gate_q;
        if (en_load) gate_d.en = en_value;
        gate_d.irq = gate_q.en & (|live);
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    assign enable_o = gate_q.en;
    assign irq_o    = gate_q.irq;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
#(
    parameter int SRC_W  = ISU_SRC_W,
    parameter int EN_BIT = ISU_EN_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [EN_BIT:0]   wr_data,
    output logic [SRC_W-1:0]  status_o,
    output logic [SRC_W-1:0]  mask_o,
    output logic              enable_o,
    output logic              irq_o
);
    localparam int DATA_W = EN_BIT + 1;

    wr_sel_e    sel;
    logic       hit_status, hit_mask, hit_enable;

    assign sel        = wr_sel_e'(wr_sel);
    assign hit_status = wr_en && (sel == SEL_STATUS);
    assign hit_mask   = wr_en && (sel == SEL_MASK);
    assign hit_enable = wr_en && (sel == SEL_ENABLE);

    isu_status_bank #(.SRC_W(SRC_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .clr_en    (hit_status),
        .keep_mask (wr_data[SRC_W-1:0]),
        .status_o  (status_o)
    );

    isu_mask_reg #(.SRC_W(SRC_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .load   (hit_mask),
        .value  (wr_data[SRC_W-1:0]),
        .mask_o (mask_o)
    );

    isu_irq_gate #(.SRC_W(SRC_W)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .en_load  (hit_enable),
        .en_value (wr_data[DATA_W-1]),
        .status_i (status_o),
        .mask_i   (mask_o),
        .enable_o (enable_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int SRC_W  = 11,
    parameter int EN_BIT = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [SRC_W-1:0] evt_i,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [EN_BIT:0]  wr_data,
    input logic [SRC_W-1:0] status_o,
    input logic [SRC_W-1:0] mask_o,
    input logic             enable_o,
    input logic             irq_o
);
    // R2: a pulsed source is set after the edge
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R3: with no event, a status write keeps only the bits written as 1
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && evt_i == '0)
        |=> (status_o == ($past(status_o) & $past(wr_data[SRC_W-1:0]))));

    // R4: an event survives a same-cycle clear of its bit
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && (|evt_i))
        |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R5: mask write loads the mask
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> (mask_o == $past(wr_data[SRC_W-1:0])));

    // R6: interrupt follows the gated, masked status one cycle later
    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == ($past(enable_o) && (|($past(status_o) & ~$past(mask_o))))));

    // R7: a cleared enable keeps the line quiet
    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !enable_o |=> !irq_o);

    // R8: select code 3 writes nothing
    assert_no_target_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3 && evt_i == '0)
        |=> ($stable(status_o) && $stable(mask_o) && $stable(enable_o)));
endmodule

bind irq_status_unit irq_status_unit_chk #(.SRC_W(SRC_W), .EN_BIT(EN_BIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .status_o (status_o),
    .mask_o   (mask_o),
    .enable_o (enable_o),
    .irq_o    (irq_o)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
    localparam int W = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  evt_i = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [W:0]    wr_data = '0;
    logic [W-1:0]  status_o, mask_o;
    logic          enable_o, irq_o;

    always #2 clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status_o(status_o), .mask_o(mask_o),
        .enable_o(enable_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [W-1:0] st;
        logic [W-1:0] mk;
        logic         en;
        logic         irq;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference model built from the requirements
    logic [W-1:0] m_st = '0;
    logic [W-1:0] m_mk = '1;
    logic         m_en = 1'b0;
    logic         m_irq = 1'b0;

    task automatic push(string tag);
        exp_t e;
        e.st = m_st; e.mk = m_mk; e.en = m_en; e.irq = m_irq; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic [W-1:0] ev, input logic we,
                        input logic [1:0] sel, input logic [W:0] d, input string tag);
        @(negedge clk);
        evt_i = ev; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        m_irq = m_en & (|(m_st & ~m_mk));
        if (we && sel == 2'd0) m_st = m_st & d[W-1:0];
        m_st = m_st | ev;
        if (we && sel == 2'd1) m_mk = d[W-1:0];
        if (we && sel == 2'd2) m_en = d[W];
        push(tag);
        #0;
    endtask

    // monitor: pops expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (status_o !== e.st || mask_o !== e.mk || enable_o !== e.en || irq_o !== e.irq) begin
                errors++;
                $display("FAIL %s: got st=%h mk=%h en=%b irq=%b exp st=%h mk=%h en=%b irq=%b",
                         e.tag, status_o, mask_o, enable_o, irq_o, e.st, e.mk, e.en, e.irq);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step('0, 0, 2'd0, '0, "R1 reset state");
        // R2/R9: device source (bit 0) captured and held
        step(11'h001, 0, 2'd0, '0, "R2 R9 device event");
        step('0, 0, 2'd0, '0, "R2 hold");
        step(11'h088, 0, 2'd0, '0, "R2 R9 link and bit7 events");
        // R3: clear only the link bit (bit 3)
        step('0, 1, 2'd0, 12'h7F7, "R3 clear link bit");
        // R5: unmask device source, status unchanged
        step('0, 1, 2'd1, 12'h7FE, "R5 unmask device");
        // R6: enable via bit 11, lower bits ignored
        step('0, 1, 2'd2, 12'h800, "R6 enable");
        step('0, 0, 2'd0, '0, "R6 irq rises");
        step('0, 0, 2'd0, '0, "R6 irq holds");
        // R7: enable cleared while lower bits all ones
        step('0, 1, 2'd2, 12'h7FF, "R7 disable");
        step('0, 0, 2'd0, '0, "R7 irq falls");
        step('0, 0, 2'd0, '0, "R7 stays low");
        step('0, 1, 2'd2, 12'h800, "R7 re-enable");
        // R8: select 3 writes nothing
        step('0, 1, 2'd3, 12'h000, "R8 no target");
        step('0, 0, 2'd0, '0, "R8 state kept");
        // R4: clear all while device event arrives
        step(11'h001, 1, 2'd0, 12'h000, "R4 set beats clear");
        step('0, 0, 2'd0, '0, "R4 irq stays");
        // R3: full clear
        step('0, 1, 2'd0, 12'h000, "R3 clear all");
        step('0, 0, 2'd0, '0, "R3 irq drops");
        // R5: masked source still recorded, no interrupt
        step(11'h020, 0, 2'd0, '0, "R5 masked capture");
        step('0, 0, 2'd0, '0, "R5 masked no irq");
        step('0, 1, 2'd1, 12'h7DF, "R5 unmask bit5");
        step('0, 0, 2'd0, '0, "R6 irq after unmask");
        step('0, 0, 2'd0, '0, "R6 final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule